// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block sits beside one processor core and turns the interrupt sources around that core into single-cycle delivery pulses. The sources are four asynchronous pins (two general local lines, a system-management line and an init line), three synchronous event strobes (thermal, performance-monitor and internal error), and inter-processor messages arriving over a valid/ready handshake. The outputs are one-cycle pulses for maskable interrupt, NMI, SMI, INIT and startup. A shared vector bus carries the vector for the maskable and startup kinds.

A small write-only register port sets a global enable, the core's own ID and one table entry for each of the five local sources. While the router is off, the two general lines follow a fixed legacy routing and everything else except the SMI and INIT lines is discarded. While it is on, the table decides what each local source becomes. Messages are taken only when their destination matches the core ID. Requests that meet in the same cycle wait in per-source slots and leave one per cycle in a fixed order.

Top module: `lirq_router`

## Requirements
- R1: After reset the router is disabled, the core ID is 0, every table entry is masked with type 0 and vector 0, no output pulses, and `ipi_ready` is high.
- R2: A rising edge on `pin_init` or `pin_smi` yields exactly one `o_init` or `o_smi` pulse, whether or not the router is enabled. A pin held high yields no further pulse.
- R3: While disabled, a rising edge on `pin_lint0` yields one `o_intr` pulse with `o_vec` = 0, and a rising edge on `pin_lint1` yields one `o_nmi` pulse.
- R4: While disabled, the thermal, performance and error strobes produce nothing. Inter-processor messages are consumed by the handshake and then dropped.
- R5: Register writes use `cfg_addr` and `cfg_wdata`. Address 0 holds the enable in bit 0 and the core ID in bits [11:4]. Addresses 1 to 5 hold the entries for `pin_lint0`, `pin_lint1`, thermal, performance and error, with mask in bit 0 (1 = masked), type in bits [3:1] and vector in bits [11:4]. Type codes are 0 maskable, 1 SMI, 2 NMI, 3 INIT, 4 startup, and 5 to 7 are reserved. Writes to addresses 6 and 7 have no effect.
- R6: While enabled, an event on a source whose entry is unmasked produces one pulse of the entry's type. `o_vec` carries the entry vector for maskable and startup pulses and is 0 for every other pulse.
- R7: While enabled, an event on a masked entry, or on an entry holding a reserved type, produces no pulse.
- R8: A message is accepted in a cycle where `ipi_valid` and `ipi_ready` are both high. It is acted on only if the router is enabled, `ipi_dest` equals the core ID and `ipi_type` is not reserved. It then produces one pulse of `ipi_type`, using the R5 type codes, with `ipi_vec` on `o_vec` for maskable and startup.
- R9: At most one output pulse is raised in any cycle, and waiting requests leave on consecutive cycles.
- R10: Waiting requests leave in this order: INIT pin, SMI pin, table sources whose type is NMI (lower address first), the inter-processor message, then the remaining table sources by address.
- R11: `ipi_ready` is high when no message is waiting or the waiting message is delivered in this cycle. Otherwise it is low.
- R12: A new request from a source that is already waiting and not delivered in that cycle is merged into the waiting request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 12 | Register write data |
| pin_lint0 | input | 1 | General local line 0 (asynchronous) |
| pin_lint1 | input | 1 | General local line 1 (asynchronous) |
| pin_smi | input | 1 | System-management line (asynchronous) |
| pin_init | input | 1 | Init line (asynchronous) |
| ev_therm | input | 1 | Thermal event strobe |
| ev_perf | input | 1 | Performance-monitor event strobe |
| ev_err | input | 1 | Internal-error event strobe |
| ipi_valid | input | 1 | Message valid |
| ipi_ready | output | 1 | Message can be taken |
| ipi_type | input | 3 | Message delivery type |
| ipi_dest | input | 8 | Message destination ID |
| ipi_vec | input | 8 | Message vector |
| o_intr | output | 1 | Maskable interrupt pulse |
| o_nmi | output | 1 | NMI pulse |
| o_smi | output | 1 | SMI pulse |
| o_init | output | 1 | INIT pulse |
| o_start | output | 1 | Startup pulse |
| o_vec | output | 8 | Vector for maskable and startup pulses |

## Verification
The assertions assume that event strobes last one cycle and that a message is held steady while `ipi_valid` is high and `ipi_ready` is low. They also assume that each asynchronous pin stays at a level for at least two clocks, so that the synchroniser sees every edge. The stimulus drives every input at the falling clock edge. It holds pins for four or more cycles and keeps the message fields fixed until the handshake completes. It raises strobes for exactly one cycle, except in the merge test, where a second single-cycle strobe follows the first on purpose.

// File: rtl/lirq_pkg.sv
// Shared widths, delivery-type codes and record types for the local interrupt router.
// Assumes type codes above DT_START are reserved and never delivered.
package lirq_pkg;
    parameter int ID_W    = 8;
    parameter int VEC_W   = 8;
    parameter int TYPE_W  = 3;
    parameter int N_LVT   = 5;
    parameter int CFG_AW  = 3;
    localparam int CFG_DW = 1 + TYPE_W + VEC_W;
    localparam int N_PIN  = 4;
    localparam int LEGACY_N = 2;

    typedef enum logic [TYPE_W-1:0] {
        DT_INTR  = 3'd0,
        DT_SMI   = 3'd1,
        DT_NMI   = 3'd2,
        DT_INIT  = 3'd3,
        DT_START = 3'd4
    } dtype_e;

    typedef struct packed {
        logic             masked;
        dtype_e           dtype;
        logic [VEC_W-1:0] vec;
    } lvt_t;

    typedef struct packed {
        dtype_e           dtype;
        logic [VEC_W-1:0] vec;
    } dlv_t;

    // True for the five type codes that produce a delivery.
    function automatic logic type_ok(input logic [TYPE_W-1:0] t);
        return t <= TYPE_W'(DT_START);
    endfunction
endpackage

// File: rtl/lirq_pins.sv
// Synchronises N asynchronous pins through STAGES flops and flags each rising edge
// for one cycle. Assumes every pin level lasts at least two clocks.
module lirq_pins #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] rise
);
    for (genvar g = 0; g < N; g++) begin : g_pin
        logic [STAGES:0] sh;

        // Shift the pin through the synchroniser plus one history flop.
        always_ff @(posedge clk) begin
            if (!rst_n) sh <= '0;
            else        sh <= {sh[STAGES-1:0], pin[g]};
        end

        assign rise[g] = sh[STAGES-1] & ~sh[STAGES];
    end
endmodule

// File: rtl/lirq_regs.sv
// Write-only configuration: global enable, core ID and one table entry per local
// source. Assumes address 0 is control and addresses 1..N_LVT are table entries.
module lirq_regs
    import lirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CFG_AW-1:0] addr,
    input  logic [CFG_DW-1:0] wdata,
    output logic              en,
    output logic [ID_W-1:0]   core_id,
    output lvt_t              lvt [N_LVT]
);
    // Control register: enable bit and local core ID.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en      <= 1'b0;
            core_id <= '0;
        end else if (we && addr == '0) begin
            en      <= wdata[0];
            core_id <= wdata[1+TYPE_W +: ID_W];
        end
    end

    // Table entries: reset to masked, updated on a matching address.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_LVT; i++) begin
            if (!rst_n) begin
                lvt[i] <= '{masked: 1'b1, dtype: DT_INTR, vec: '0};
            end else if (we && addr == CFG_AW'(i + 1)) begin
                lvt[i] <= '{masked: wdata[0],
                            dtype:  dtype_e'(wdata[TYPE_W:1]),
                            vec:    wdata[1+TYPE_W +: VEC_W]};
            end
        end
    end
endmodule

// File: rtl/lirq_core.sv
// Resolves each request to a delivery type at capture time, holds it in a per-source
// slot, and delivers one slot per cycle in fixed order as a registered pulse.
// Assumes a message is held stable while ipi_valid is high and ipi_ready is low.
module lirq_core
    import lirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [ID_W-1:0]   core_id,
    input  lvt_t              lvt [N_LVT],
    input  logic              init_rise,
    input  logic              smi_rise,
    input  logic [N_LVT-1:0]  lsrc,
    input  logic              ipi_valid,
    output logic              ipi_ready,
    input  logic [TYPE_W-1:0] ipi_type,
    input  logic [ID_W-1:0]   ipi_dest,
    input  logic [VEC_W-1:0]  ipi_vec,
    output logic              o_intr,
    output logic              o_nmi,
    output logic              o_smi,
    output logic              o_init,
    output logic              o_start,
    output logic [VEC_W-1:0]  o_vec
);
    localparam int N_SLOT = 2 + N_LVT;

    logic [N_SLOT-1:0] r_req;
    dlv_t              r_dlv [N_SLOT];
    logic [N_SLOT-1:0] s_pend;
    dlv_t              s_dlv [N_SLOT];
    logic [N_SLOT-1:0] grant;
    logic              ipi_pend;
    dlv_t              ipi_dlv;
    logic              g_ipi;
    logic              hit;
    logic              ipi_take;
    logic              any;
    dlv_t              sel;

    // Map each incoming request to a delivery, per enable state and table entry.
    always_comb begin
        r_req[0] = init_rise;
        r_dlv[0] = '{dtype: DT_INIT, vec: '0};
        r_req[1] = smi_rise;
        r_dlv[1] = '{dtype: DT_SMI, vec: '0};
        for (int i = 0; i < N_LVT; i++) begin
            if (en) begin
                r_req[2+i] = lsrc[i] && !lvt[i].masked && type_ok(lvt[i].dtype);
                r_dlv[2+i] = '{dtype: lvt[i].dtype, vec: lvt[i].vec};
            end else begin
                r_req[2+i] = lsrc[i] && (i < LEGACY_N);
                r_dlv[2+i] = '{dtype: (i == 0) ? DT_INTR : DT_NMI, vec: '0};
            end
        end
    end

    // Fixed-order pick: INIT pin, SMI pin, NMI-typed table slots, message, other table slots.
    always_comb begin
        grant = '0;
        g_ipi = 1'b0;
        hit   = 1'b0;
        if (s_pend[0]) begin
            grant[0] = 1'b1;
            hit      = 1'b1;
        end else if (s_pend[1]) begin
            grant[1] = 1'b1;
            hit      = 1'b1;
        end
        for (int i = 2; i < N_SLOT; i++) begin
            if (!hit && s_pend[i] && s_dlv[i].dtype == DT_NMI) begin
                grant[i] = 1'b1;
                hit      = 1'b1;
            end
        end
        if (!hit && ipi_pend) begin
            g_ipi = 1'b1;
            hit   = 1'b1;
        end
        for (int i = 2; i < N_SLOT; i++) begin
            if (!hit && s_pend[i]) begin
                grant[i] = 1'b1;
                hit      = 1'b1;
            end
        end
    end

    assign ipi_ready = !ipi_pend || g_ipi;
    assign ipi_take  = ipi_valid && ipi_ready && en && (ipi_dest == core_id) && type_ok(ipi_type);

    // Source slots: load on a request when free or leaving, clear when delivered.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_SLOT; i++) begin
            if (!rst_n) begin
                s_pend[i] <= 1'b0;
                s_dlv[i]  <= '{dtype: DT_INTR, vec: '0};
            end else if (r_req[i] && (!s_pend[i] || grant[i])) begin
                s_pend[i] <= 1'b1;
                s_dlv[i]  <= r_dlv[i];
            end else if (grant[i]) begin
                s_pend[i] <= 1'b0;
            end
        end
    end

    // Message slot: holds one accepted and matching message until delivered.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ipi_pend <= 1'b0;
            ipi_dlv  <= '{dtype: DT_INTR, vec: '0};
        end else if (ipi_take) begin
            ipi_pend <= 1'b1;
            ipi_dlv  <= '{dtype: dtype_e'(ipi_type), vec: ipi_vec};
        end else if (g_ipi) begin
            ipi_pend <= 1'b0;
        end
    end

    // Select the granted record.
    always_comb begin
        sel = '{dtype: DT_INTR, vec: '0};
        for (int i = 0; i < N_SLOT; i++) begin
            if (grant[i]) sel = s_dlv[i];
        end
        if (g_ipi) sel = ipi_dlv;
        any = |grant || g_ipi;
    end

    // Register the one-cycle delivery pulses and the vector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_intr  <= 1'b0;
            o_nmi   <= 1'b0;
            o_smi   <= 1'b0;
            o_init  <= 1'b0;
            o_start <= 1'b0;
            o_vec   <= '0;
        end else begin
            o_intr  <= any && sel.dtype == DT_INTR;
            o_nmi   <= any && sel.dtype == DT_NMI;
            o_smi   <= any && sel.dtype == DT_SMI;
            o_init  <= any && sel.dtype == DT_INIT;
            o_start <= any && sel.dtype == DT_START;
            o_vec   <= (any && (sel.dtype == DT_INTR || sel.dtype == DT_START)) ? sel.vec : '0;
        end
    end
endmodule

// File: rtl/lirq_router.sv
// Top of the per-core local interrupt router: pin synchroniser, configuration
// registers and the capture/delivery core. Pins are asynchronous; strobes are
// synchronous one-cycle pulses.
module lirq_router
    import lirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_DW-1:0] cfg_wdata,
    input  logic              pin_lint0,
    input  logic              pin_lint1,
    input  logic              pin_smi,
    input  logic              pin_init,
    input  logic              ev_therm,
    input  logic              ev_perf,
    input  logic              ev_err,
    input  logic              ipi_valid,
    output logic              ipi_ready,
    input  logic [TYPE_W-1:0] ipi_type,
    input  logic [ID_W-1:0]   ipi_dest,
    input  logic [VEC_W-1:0]  ipi_vec,
    output logic              o_intr,
    output logic              o_nmi,
    output logic              o_smi,
    output logic              o_init,
    output logic              o_start,
    output logic [VEC_W-1:0]  o_vec
);
    logic [N_PIN-1:0] pin_rise;
    logic             cfg_en;
    logic [ID_W-1:0]  cfg_id;
    lvt_t             cfg_lvt [N_LVT];
    logic [N_LVT-1:0] lsrc;

    lirq_pins #(.N(N_PIN), .STAGES(SYNC_STAGES)) u_pins (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  ({pin_init, pin_smi, pin_lint1, pin_lint0}),
        .rise (pin_rise)
    );

    lirq_regs u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (cfg_we),
        .addr   (cfg_addr),
        .wdata  (cfg_wdata),
        .en     (cfg_en),
        .core_id(cfg_id),
        .lvt    (cfg_lvt)
    );

    assign lsrc = {ev_err, ev_perf, ev_therm, pin_rise[1], pin_rise[0]};

    lirq_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (cfg_en),
        .core_id  (cfg_id),
        .lvt      (cfg_lvt),
        .init_rise(pin_rise[3]),
        .smi_rise (pin_rise[2]),
        .lsrc     (lsrc),
        .ipi_valid(ipi_valid),
        .ipi_ready(ipi_ready),
        .ipi_type (ipi_type),
        .ipi_dest (ipi_dest),
        .ipi_vec  (ipi_vec),
        .o_intr   (o_intr),
        .o_nmi    (o_nmi),
        .o_smi    (o_smi),
        .o_init   (o_init),
        .o_start  (o_start),
        .o_vec    (o_vec)
    );
endmodule

// File: rtl/lirq_router_chk.sv
// Property checker for lirq_router, attached with bind. Assumes the synchronised
// INIT edge and the enable bit are visible at the top level.
module lirq_router_chk
    import lirq_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             en,
    input logic             rise_init,
    input logic             ipi_valid,
    input logic             ipi_ready,
    input logic             o_intr,
    input logic             o_nmi,
    input logic             o_smi,
    input logic             o_init,
    input logic             o_start,
    input logic [VEC_W-1:0] o_vec
);
    // R9: never more than one delivery pulse in a cycle.
    p_one_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({o_intr, o_nmi, o_smi, o_init, o_start}));

    // R6: vector bus is quiet unless a maskable or startup pulse is out.
    p_vec_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!o_intr && !o_start) |-> (o_vec == '0));

    // R2: a synchronised INIT edge is delivered two cycles later (top order).
    p_init_pin_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise_init |=> ##1 o_init);

    // R4: a message taken while disabled leaves the slot free.
    p_ipi_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ipi_valid && ipi_ready && !en) |=> ipi_ready);
endmodule

bind lirq_router lirq_router_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg_en),
    .rise_init(pin_rise[3]),
    .ipi_valid(ipi_valid),
    .ipi_ready(ipi_ready),
    .o_intr   (o_intr),
    .o_nmi    (o_nmi),
    .o_smi    (o_smi),
    .o_init   (o_init),
    .o_start  (o_start),
    .o_vec    (o_vec)
);

// File: tb/lirq_router_test.sv
module lirq_router_test;
    import lirq_pkg::*;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [11:0] cfg_wdata = '0;
    logic pin_lint0 = 0, pin_lint1 = 0, pin_smi = 0, pin_init = 0;
    logic ev_therm = 0, ev_perf = 0, ev_err = 0;
    logic       ipi_valid = 0;
    logic       ipi_ready;
    logic [2:0] ipi_type = '0;
    logic [7:0] ipi_dest = '0, ipi_vec = '0;
    logic o_intr, o_nmi, o_smi, o_init, o_start;
    logic [7:0] o_vec;

    lirq_router uut (.*);

    int total = 0, bad = 0, cyc = 0, multi = 0, lg_n = 0;
    bit done = 0;
    logic [2:0] lg_t [64];
    logic [7:0] lg_v [64];
    int         lg_c [64];

    always @(posedge clk) cyc <= cyc + 1;

    // Delivery log, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && (o_intr | o_nmi | o_smi | o_init | o_start)) begin
            if ($countones({o_intr, o_nmi, o_smi, o_init, o_start}) > 1) multi = multi + 1;
            lg_t[lg_n % 64] = o_intr ? 3'd0 : o_smi ? 3'd1 : o_nmi ? 3'd2 : o_init ? 3'd3 : 3'd4;
            lg_v[lg_n % 64] = o_vec;
            lg_c[lg_n % 64] = cyc;
            lg_n = lg_n + 1;
        end
    end

    task automatic chk(input bit ok, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic cfg_wr(input logic [2:0] a, input logic [11:0] d);
        @(negedge clk);
        cfg_we = 1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_ipi(input logic [2:0] t, input logic [7:0] d, input logic [7:0] v);
        @(negedge clk);
        ipi_valid = 1; ipi_type = t; ipi_dest = d; ipi_vec = v;
        forever begin
            bit r;
            r = ipi_ready;
            @(posedge clk);
            if (r) break;
            @(negedge clk);
        end
        @(negedge clk);
        ipi_valid = 0;
    endtask

    task automatic pulse_pin(input int which);
        @(negedge clk);
        case (which)
            0: pin_lint0 = 1; 1: pin_lint1 = 1; 2: pin_smi = 1; default: pin_init = 1;
        endcase
        idle(4);
        pin_lint0 = 0; pin_lint1 = 0; pin_smi = 0; pin_init = 0;
        idle(3);
    endtask

    task automatic strobe(input int which);
        @(negedge clk);
        case (which)
            2: ev_therm = 1; 3: ev_perf = 1; default: ev_err = 1;
        endcase
        @(negedge clk);
        ev_therm = 0; ev_perf = 0; ev_err = 0;
    endtask

    // src: 0 lint0, 1 lint1, 2 therm, 3 perf, 4 err, 5 smi pin, 6 init pin,
    //      7 message to own ID, 8 message to another ID
    typedef struct packed {
        logic [3:0] req;
        logic       en;
        logic       mask;
        logic [2:0] typ;
        logic [7:0] vin;
        logic [3:0] src;
        logic [1:0] n;
        logic [2:0] t;
        logic [7:0] v;
    } row_t;

    localparam int NROW = 16;
    localparam row_t ROWS [NROW] = '{
        '{4'd2,  1'b0, 1'b1, 3'd0, 8'h00, 4'd6, 2'd1, 3'd3, 8'h00}, // R2 init pin, disabled
        '{4'd2,  1'b0, 1'b1, 3'd0, 8'h00, 4'd5, 2'd1, 3'd1, 8'h00}, // R2 smi pin, disabled
        '{4'd3,  1'b0, 1'b1, 3'd2, 8'h66, 4'd0, 2'd1, 3'd0, 8'h00}, // R3 lint0 legacy
        '{4'd3,  1'b0, 1'b1, 3'd0, 8'h66, 4'd1, 2'd1, 3'd2, 8'h00}, // R3 lint1 legacy
        '{4'd4,  1'b0, 1'b0, 3'd2, 8'h10, 4'd2, 2'd0, 3'd0, 8'h00}, // R4 thermal dropped
        '{4'd4,  1'b0, 1'b0, 3'd0, 8'h22, 4'd7, 2'd0, 3'd0, 8'h00}, // R4 message dropped
        '{4'd6,  1'b1, 1'b0, 3'd0, 8'h41, 4'd0, 2'd1, 3'd0, 8'h41}, // R6 lint0 maskable
        '{4'd6,  1'b1, 1'b0, 3'd4, 8'h9A, 4'd1, 2'd1, 3'd4, 8'h9A}, // R6 lint1 startup
        '{4'd6,  1'b1, 1'b0, 3'd2, 8'h77, 4'd2, 2'd1, 3'd2, 8'h00}, // R6 thermal NMI
        '{4'd7,  1'b1, 1'b1, 3'd0, 8'h12, 4'd3, 2'd0, 3'd0, 8'h00}, // R7 perf masked
        '{4'd7,  1'b1, 1'b0, 3'd6, 8'h55, 4'd4, 2'd0, 3'd0, 8'h00}, // R7 reserved type
        '{4'd5,  1'b1, 1'b0, 3'd1, 8'h00, 4'd4, 2'd1, 3'd1, 8'h00}, // R5 error entry SMI
        '{4'd8,  1'b1, 1'b0, 3'd4, 8'hC3, 4'd7, 2'd1, 3'd4, 8'hC3}, // R8 message startup
        '{4'd8,  1'b1, 1'b0, 3'd2, 8'h00, 4'd8, 2'd0, 3'd0, 8'h00}, // R8 wrong destination
        '{4'd2,  1'b1, 1'b1, 3'd0, 8'h00, 4'd6, 2'd1, 3'd3, 8'h00}, // R2 init pin, enabled
        '{4'd2,  1'b1, 1'b1, 3'd0, 8'h00, 4'd5, 2'd1, 3'd1, 8'h00}  // R2 smi pin, enabled
    };

    initial begin
        int base;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        // R1: outputs quiet and handshake open after reset.
        chk({o_intr, o_nmi, o_smi, o_init, o_start} == 5'd0 && o_vec == 0, "R1 reset outputs",
            {o_intr, o_nmi, o_smi, o_init, o_start}, 0);
        chk(ipi_ready == 1, "R1 reset ipi_ready", ipi_ready, 1);

        // R1: enable only; table still masked, ID still 0.
        cfg_wr(3'd0, 12'h001);
        base = lg_n;
        strobe(2);
        idle(6);
        chk(lg_n - base == 0, "R1 default entry masked", lg_n - base, 0);
        base = lg_n;
        send_ipi(3'd2, 8'h00, 8'h00);
        idle(6);
        chk(lg_n - base == 1, "R1 default core ID zero count", lg_n - base, 1);
        chk(lg_t[base % 64] == 3'd2, "R1 default core ID type", lg_t[base % 64], 2);

        // Table-driven rows.
        for (int i = 0; i < NROW; i++) begin
            row_t r;
            r = ROWS[i];
            cfg_wr(3'd0, {8'h5A, 3'd0, r.en});
            if (r.src < 5) cfg_wr(3'(r.src + 1), {r.vin, r.typ, r.mask});
            idle(2);
            base = lg_n;
            case (r.src)
                4'd0: pulse_pin(0);
                4'd1: pulse_pin(1);
                4'd5: pulse_pin(2);
                4'd6: pulse_pin(3);
                4'd7: send_ipi(r.typ, 8'h5A, r.vin);
                4'd8: send_ipi(r.typ, 8'h5B, r.vin);
                default: strobe(int'(r.src));
            endcase
            idle(10);
            chk(lg_n - base == int'(r.n), $sformatf("R%0d row %0d count", r.req, i), lg_n - base, r.n);
            if (r.n == 2'd1 && lg_n - base == 1) begin
                chk(lg_t[base % 64] == r.t, $sformatf("R%0d row %0d type", r.req, i), lg_t[base % 64], r.t);
                chk(lg_v[base % 64] == r.v, $sformatf("R%0d row %0d vector", r.req, i), lg_v[base % 64], r.v);
            end
        end

        // R5: writes to address 7 change nothing (lint0 entry keeps maskable 0x41).
        cfg_wr(3'd1, {8'h41, 3'd0, 1'b0});
        cfg_wr(3'd7, 12'hFFF);
        base = lg_n;
        pulse_pin(0);
        idle(6);
        chk(lg_n - base == 1 && lg_v[base % 64] == 8'h41, "R5 address 7 ignored", lg_v[base % 64], 8'h41);

        // R10, R11, R12, R9: thermal maskable 0x33, error NMI, message maskable 0x44 together.
        cfg_wr(3'd3, {8'h33, 3'd0, 1'b0});
        cfg_wr(3'd5, {8'h00, 3'd2, 1'b0});
        idle(2);
        base = lg_n;
        @(negedge clk);
        ev_therm = 1; ev_err = 1;
        ipi_valid = 1; ipi_type = 3'd0; ipi_dest = 8'h5A; ipi_vec = 8'h44;
        @(negedge clk);
        ev_err = 0; ipi_valid = 0;   // ev_therm repeats for one more cycle (R12)
        chk(ipi_ready == 0, "R11 ready low while message waits", ipi_ready, 0);
        @(negedge clk);
        ev_therm = 0;
        chk(ipi_ready == 1, "R11 ready high when message leaves", ipi_ready, 1);
        idle(8);
        chk(lg_n - base == 3, "R12 repeat thermal merged", lg_n - base, 3);
        chk(lg_t[base % 64] == 3'd2, "R10 NMI first", lg_t[base % 64], 2);
        chk(lg_t[(base + 1) % 64] == 3'd0 && lg_v[(base + 1) % 64] == 8'h44, "R10 message second",
            lg_v[(base + 1) % 64], 8'h44);
        chk(lg_v[(base + 2) % 64] == 8'h33, "R10 thermal last", lg_v[(base + 2) % 64], 8'h33);
        chk(lg_c[(base + 1) % 64] == lg_c[base % 64] + 1 && lg_c[(base + 2) % 64] == lg_c[base % 64] + 2,
            "R9 consecutive cycles", lg_c[(base + 2) % 64] - lg_c[base % 64], 2);

        // R10: INIT and SMI pins rise together; INIT leaves first.
        base = lg_n;
        @(negedge clk);
        pin_init = 1; pin_smi = 1;
        idle(4);
        pin_init = 0; pin_smi = 0;
        idle(6);
        chk(lg_n - base == 2, "R10 pin pair count", lg_n - base, 2);
        chk(lg_t[base % 64] == 3'd3 && lg_t[(base + 1) % 64] == 3'd1, "R10 INIT before SMI",
            lg_t[base % 64], 3);

        chk(multi == 0, "R9 one pulse per cycle", multi, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        done = 1;
        $finish;
    end

    initial begin
        #1_000_000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=done", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule